// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a real-mode segment and offset into a linear address and decides, in the same step, whether the access must fault instead. The linear address is the segment value multiplied by sixteen plus the low sixteen bits of the effective address. The sum is kept to 21 bits, so an access near the top of the first megabyte produces an address above it rather than wrapping to the bottom.

Each request is checked for three faults: an effective address that does not fit in sixteen bits, an operand whose last byte lies past offset FFFFH, and an instruction fetch that would run off the top of the segment. A stack access that faults reports vector 12. Any other access reports vector 13. A request is presented for one cycle with `reqValid`, and one clock later the block raises exactly one of `accValid` or `faultValid`.

Top module: `rm_addr_gen`

## Requirements
- R1: While `rstN` is low, `linAddr`, `faultVec`, `accValid` and `faultValid` are all zero.
- R2: For a request that does not fault, `linAddr` equals segVal*16 + effAddr[15:0], computed to 21 bits. Bit 20 keeps the carry, so segment FFFFH with offset FFFFH gives 10FFEFH.
- R3: Results appear one clock after the edge that samples `reqValid` high. In a cycle that follows no request, both strobes are low and `linAddr` and `faultVec` keep their values.
- R4: If any of effAddr[31:16] is set, the request faults. The vector is 12 for a stack access that is not a fetch, and 13 otherwise.
- R5: `opSize` sets the operand length: 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes. A data access whose last byte (effAddr[15:0] + length - 1) exceeds FFFFH faults with vector 13 when `isStack` is 0.
- R6: A stack access (`isStack`=1, `isFetch`=0) that crosses FFFFH faults with vector 12. This covers a word push with SP=1, which is presented as offset FFFFH with length 2, and so covers the crossing of offset 0.
- R7: A fetch (`isFetch`=1) that would run past FFFFH faults with vector 13, whatever the value of `isStack`. A fetch that ends exactly at FFFFH does not fault.
- R8: On a faulting request, `linAddr` keeps its previous value and `accValid` stays low. Between faults, `faultVec` keeps the last vector.
- R9: `accValid` and `faultValid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| segVal | input | 16 | Segment value |
| effAddr | input | 32 | Effective address (offset) |
| opSize | input | 2 | Operand length code: 0=1, 1=2, 2 or 3=4 bytes |
| isStack | input | 1 | Access goes through the stack segment |
| isFetch | input | 1 | Access is an instruction fetch |
| linAddr | output | 21 | Registered linear address |
| accValid | output | 1 | Registered: access allowed, `linAddr` is new |
| faultValid | output | 1 | Registered: access faulted |
| faultVec | output | 8 | Registered fault vector (12 or 13) |

## Verification
The bench goes after the edges of the offset space:
- the largest segment and offset together, which a design that drops the carry would turn into FFEFH;
- a 4-byte operand that ends exactly at FFFFH, and one that ends a byte or two past it, where an off-by-one in the end-offset sum either faults the legal case or lets the illegal one through;
- the word push at offset FFFFH and a fetch tagged as a stack access, where a vector priority that is swapped or missing reports 13 for the stack case or 12 for the fetch.

It also sends effective addresses with only high bits set, which a check that looks only at the low word would accept. Idle cycles and faulting cycles confirm that the address output is left untouched, since a design that loaded it on every request would expose the address of the faulting access.

// File: rtl/rm_addr_pkg.sv
package rm_addr_pkg;
  localparam int VEC_W = 8;
  localparam logic [VEC_W-1:0] VEC_STACK = 8'd12;
  localparam logic [VEC_W-1:0] VEC_GP    = 8'd13;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_WIDE  = 2'd3
  } op_size_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             loadAddr;
    logic             raiseFault;
    logic [VEC_W-1:0] vec;
  } addr_strobe_t;
endpackage

// File: rtl/rm_addr_ctl.sv
module rm_addr_ctl
  import rm_addr_pkg::*;
#(
  parameter int EA_W  = 32,
  parameter int OFF_W = 16
) (
  input  logic            reqValid,
  input  logic [EA_W-1:0] effAddr,
  input  logic [1:0]      opSize,
  input  logic            isStack,
  input  logic            isFetch,
  output addr_strobe_t    strobe
);
  logic [OFF_W:0] lastByte;
  logic [2:0]     sizeM1;
  logic           eaHigh;
  logic           crossTop;
  logic           anyFault;

  // length minus one, from the size code
  always_comb begin
    unique case (op_size_e'(opSize))
      SZ_BYTE:  sizeM1 = 3'd0;
      SZ_WORD:  sizeM1 = 3'd1;
      default:  sizeM1 = 3'd3;
    endcase
  end

  generate
    if (EA_W > OFF_W) begin : g_wide
      assign eaHigh = |effAddr[EA_W-1:OFF_W];
    end else begin : g_narrow
      assign eaHigh = 1'b0;
    end
  endgenerate

  assign lastByte = {1'b0, effAddr[OFF_W-1:0]} + {{(OFF_W-2){1'b0}}, sizeM1};
  assign crossTop = lastByte[OFF_W];
  assign anyFault = eaHigh | crossTop;

  always_comb begin
    strobe.loadAddr   = reqValid & ~anyFault;
    strobe.raiseFault = reqValid & anyFault;
    if (isFetch)      strobe.vec = VEC_GP;
    else if (isStack) strobe.vec = VEC_STACK;
    else              strobe.vec = VEC_GP;
  end
endmodule

// File: rtl/rm_addr_dp.sv
module rm_addr_dp
  import rm_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int LIN_W = SEG_W + SHIFT + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEG_W-1:0]  segVal,
  input  logic [OFF_W-1:0]  offset,
  input  addr_strobe_t      strobe,
  output logic [LIN_W-1:0]  linAddr,
  output logic              accValid,
  output logic              faultValid,
  output logic [VEC_W-1:0]  faultVec
);
  logic [LIN_W-1:0] baseExt;
  logic [LIN_W-1:0] offExt;
  logic [LIN_W-1:0] sum;

  assign baseExt = {1'b0, segVal, {SHIFT{1'b0}}};
  assign offExt  = {{(LIN_W-OFF_W){1'b0}}, offset};
  assign sum     = baseExt + offExt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linAddr    <= '0;
      accValid   <= 1'b0;
      faultValid <= 1'b0;
      faultVec   <= '0;
    end else begin
      accValid   <= strobe.loadAddr;
      faultValid <= strobe.raiseFault;
      if (strobe.loadAddr)   linAddr  <= sum;
      if (strobe.raiseFault) faultVec <= strobe.vec;
    end
  end

  // R9
  excl_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(accValid && faultValid));

  // R8
  hold_on_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> $stable(linAddr));
endmodule

// File: rtl/rm_addr_gen.sv
module rm_addr_gen
  import rm_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int EA_W  = 32,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int LIN_W = SEG_W + SHIFT + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [SEG_W-1:0] segVal,
  input  logic [EA_W-1:0]  effAddr,
  input  logic [1:0]       opSize,
  input  logic             isStack,
  input  logic             isFetch,
  output logic [LIN_W-1:0] linAddr,
  output logic             accValid,
  output logic             faultValid,
  output logic [7:0]       faultVec
);
  addr_strobe_t strobe;

  rm_addr_ctl #(.EA_W(EA_W), .OFF_W(OFF_W)) u_ctl (
    .reqValid(reqValid), .effAddr(effAddr), .opSize(opSize),
    .isStack(isStack), .isFetch(isFetch), .strobe(strobe)
  );

  rm_addr_dp #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .segVal(segVal), .offset(effAddr[OFF_W-1:0]),
    .strobe(strobe), .linAddr(linAddr), .accValid(accValid),
    .faultValid(faultValid), .faultVec(faultVec)
  );

  logic [LIN_W-1:0] refLin;
  assign refLin = {1'b0, segVal, {SHIFT{1'b0}}} + {{(LIN_W-OFF_W){1'b0}}, effAddr[OFF_W-1:0]};

  // R3
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid || faultValid) |-> $past(reqValid));

  // R2
  lin_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    accValid |-> (linAddr == $past(refLin)));

  // R7
  fetch_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && $past(isFetch)) |-> (faultVec == VEC_GP));

  // R4
  high_ea_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (effAddr[EA_W-1:OFF_W] != '0)) |=> (faultValid && !accValid));
endmodule

// File: tb/sim_rm_addr_gen.sv
module sim_rm_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  typedef struct packed {
    logic [15:0] seg;
    logic [31:0] ea;
    logic [1:0]  sz;
    logic        stk;
    logic        fet;
    logic        expFault;
    logic [7:0]  expVec;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{16'h1234, 32'h0000_0010, 2'd0, 1'b0, 1'b0, 1'b0, 8'd0},  // R2
    '{16'hFFFF, 32'h0000_FFFF, 2'd0, 1'b0, 1'b0, 1'b0, 8'd0},  // R2 carry into bit 20
    '{16'h0000, 32'h0000_0000, 2'd0, 1'b0, 1'b0, 1'b0, 8'd0},  // R2
    '{16'hF000, 32'h0000_FFF0, 2'd0, 1'b0, 1'b1, 1'b0, 8'd0},  // R7 legal fetch
    '{16'h1000, 32'h0001_0000, 2'd1, 1'b0, 1'b0, 1'b1, 8'd13}, // R4 data
    '{16'h1000, 32'h0001_0000, 2'd1, 1'b1, 1'b0, 1'b1, 8'd12}, // R4 stack
    '{16'h2000, 32'h0000_FFFF, 2'd1, 1'b0, 1'b0, 1'b1, 8'd13}, // R5 word crossing
    '{16'h2000, 32'h0000_FFFF, 2'd1, 1'b1, 1'b0, 1'b1, 8'd12}, // R6 push SP=1
    '{16'h2000, 32'h0000_FFFC, 2'd2, 1'b0, 1'b0, 1'b0, 8'd0},  // R5 dword at edge
    '{16'h2000, 32'h0000_FFFD, 2'd2, 1'b1, 1'b0, 1'b1, 8'd12}, // R6 dword stack
    '{16'h2000, 32'h0000_FFFE, 2'd3, 1'b0, 1'b0, 1'b1, 8'd13}, // R5 code 3 is 4 bytes
    '{16'h3000, 32'h0000_FFFF, 2'd0, 1'b1, 1'b0, 1'b0, 8'd0},  // R6 byte at top ok
    '{16'h4000, 32'h0000_FFFE, 2'd1, 1'b1, 1'b1, 1'b0, 8'd0},  // R7 fetch ends at FFFF
    '{16'h4000, 32'h0000_FFFF, 2'd1, 1'b1, 1'b1, 1'b1, 8'd13}, // R7 fetch over stack
    '{16'h0ABC, 32'h8000_0000, 2'd0, 1'b0, 1'b0, 1'b1, 8'd13}  // R4 top bit only
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] segVal = '0;
  logic [31:0] effAddr = '0;
  logic [1:0]  opSize = '0;
  logic        isStack = 1'b0;
  logic        isFetch = 1'b0;
  logic [20:0] linAddr;
  logic        accValid;
  logic        faultValid;
  logic [7:0]  faultVec;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rm_addr_gen u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .segVal(segVal),
    .effAddr(effAddr), .opSize(opSize), .isStack(isStack), .isFetch(isFetch),
    .linAddr(linAddr), .accValid(accValid), .faultValid(faultValid),
    .faultVec(faultVec)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [20:0] lastLin;
    logic [7:0]  lastVec;
    lastLin = '0;
    lastVec = '0;
    repeat (3) @(negedge clk);
    // R1 reset values, with a request pending
    reqValid = 1'b1; segVal = 16'hFFFF; effAddr = 32'h0000_FFFF;
    @(negedge clk);
    chk(linAddr == '0 && faultVec == '0, "R1 reset addr/vec", {3'b0, linAddr, faultVec}, 32'h0);
    chk(!accValid && !faultValid, "R1 reset strobes", {accValid, faultValid}, 32'h0);
    reqValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [20:0] expLin;
      reqValid = 1'b1;
      segVal = TBL[i].seg; effAddr = TBL[i].ea; opSize = TBL[i].sz;
      isStack = TBL[i].stk; isFetch = TBL[i].fet;
      @(negedge clk);
      chk(!(accValid && faultValid), $sformatf("R9 row %0d exclusive", i),
          {accValid, faultValid}, 32'h0);
      if (!TBL[i].expFault) begin
        expLin = {1'b0, TBL[i].seg, 4'h0} + {5'b0, TBL[i].ea[15:0]};
        lastLin = expLin;
        chk(accValid && !faultValid, $sformatf("R3 row %0d strobes", i),
            {accValid, faultValid}, 32'h2);
        chk(linAddr == expLin, $sformatf("R2 row %0d linAddr", i), linAddr, expLin);
      end else begin
        lastVec = TBL[i].expVec;
        chk(faultValid && !accValid, $sformatf("R4-R7 row %0d fault strobe", i),
            {accValid, faultValid}, 32'h1);
        chk(faultVec == TBL[i].expVec, $sformatf("R5 R6 R7 row %0d vector", i),
            faultVec, TBL[i].expVec);
        chk(linAddr == lastLin, $sformatf("R8 row %0d linAddr held", i), linAddr, lastLin);
      end
    end

    // R3 / R8 idle cycle with faulting-looking inputs
    reqValid = 1'b0; segVal = 16'h5555; effAddr = 32'hFFFF_FFFF; isStack = 1'b1;
    @(negedge clk);
    chk(!accValid && !faultValid, "R3 idle strobes", {accValid, faultValid}, 32'h0);
    chk(linAddr == lastLin, "R3 idle linAddr held", linAddr, lastLin);
    chk(faultVec == lastVec, "R8 idle faultVec held", faultVec, lastVec);

    // R8 back-to-back: good access then fault keeps the good address
    reqValid = 1'b1; segVal = 16'h0100; effAddr = 32'h0000_0002; opSize = 2'd2;
    isStack = 1'b0; isFetch = 1'b0;
    @(negedge clk);
    chk(accValid && linAddr == 21'h01002, "R2 directed address", linAddr, 32'h01002);
    segVal = 16'h9999; effAddr = 32'h0000_FFFF; isStack = 1'b1;
    @(negedge clk);
    chk(faultValid && faultVec == 8'd12, "R6 directed stack vector", faultVec, 32'd12);
    chk(linAddr == 21'h01002, "R8 directed hold", linAddr, 32'h01002);
    reqValid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule